// File: doc/BRIEF.md
# Per-Hart Interrupt Priority Selector with Claim

This block sits between the per-source interrupt state of a platform interrupt controller and the harts it serves, when interrupts are delivered directly over wires. Every cycle it looks at all sources that are both enabled and pending. For each hart it picks the best one among those whose target word names that hart and whose priority passes the hart's threshold. It presents the result as a top-interrupt word and raises one interrupt line per hart when delivery is allowed.

Software reaches each hart through a small 32-byte register group. The group holds a delivery-enable bit, a force bit and a threshold. It also has a read-only view of the top interrupt and a claim location. A claim read returns the top interrupt and emits one-cycle pulses that tell the source logic to clear that source's pending bit. When a level-triggered source is still active, the pulses also tell it to set the bit again. The block also owns the per-source target words and normalises their priority field on write. Pending, enable, input level and trigger mode come from the source logic as vectors.

Top module: `hart_prio_claim`

## Requirements
- R1: The target word of a source names its hart in bits 31:18 (14 bits) and its priority in bits PRIO_W-1:0. A source competes only for the hart whose index equals that field, so a hart field beyond the last hart reaches no hart.
- R2: Among the competing sources, the smallest priority number wins, and on equal priority the lowest source number wins. Source 0 never competes.
- R3: A nonzero hart threshold removes every source whose priority is greater than or equal to it. A threshold of 0 removes nothing.
- R4: The top-interrupt word, read at hart offset 0x18, is (source << 16) | priority. It is 0 when no source competes.
- R5: `irq_out[h]` is 1 exactly when `dom_ie` is 1, hart h's delivery bit is 1, and either its force bit is 1 or its top-interrupt word is nonzero.
- R6: A read at hart offset 0x1C returns the top-interrupt word. When that word is nonzero, the same cycle pulses `pend_clr` for that source. It also pulses `pend_set` for that source when the source is level-high (`src_lvl_hi` bit 1) with its input 1, or level-low (`src_lvl_lo` bit 1) with its input 0. Otherwise `pend_set` stays 0. Both vectors are zero outside a claim.
- R7: A claim read that finds no candidate returns 0, pulses nothing, and clears that hart's force bit.
- R8: A target write with priority field 0 stores priority 1. After reset every target names hart 0 with priority 1.
- R9: Hart register offsets are delivery 0x00 (bit 0 only), force 0x04 (bit 0 only) and threshold 0x08 (masked to PRIO_W bits). All reset to 0. The address is {hart, offset[4:0]}. Other offsets read 0, and writes to them change nothing.
- R10: Only sources with both `src_en` and `src_pend` set compete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_ie | input | 1 | Domain-wide interrupt enable |
| src_en | input | NUM_SRC | Per-source enable |
| src_pend | input | NUM_SRC | Per-source pending |
| src_in | input | NUM_SRC | Per-source current input level |
| src_lvl_hi | input | NUM_SRC | Source is level-triggered, active high |
| src_lvl_lo | input | NUM_SRC | Source is level-triggered, active low |
| tgt_we | input | 1 | Target word write strobe |
| tgt_sel | input | SRC_W | Source whose target word is written |
| tgt_wdata | input | 32 | Target word write data |
| reg_we | input | 1 | Hart register write strobe |
| reg_re | input | 1 | Hart register read strobe (claim has side effects) |
| reg_addr | input | HART_W+5 | {hart index, byte offset} |
| reg_wdata | input | 32 | Hart register write data |
| reg_rdata | output | 32 | Hart register read data, valid in the read cycle |
| pend_clr | output | NUM_SRC | Claim pulse: clear this source's pending bit |
| pend_set | output | NUM_SRC | Claim pulse: set pending again (level still active) |
| irq_out | output | NUM_HART | Interrupt line per hart |

## Verification
The bench goes after priority ties, where a design that scans in the wrong direction or uses a non-strict compare would report a higher source number. It also probes the threshold edge: a design that keeps priority equal to the threshold, or that treats threshold 0 as "mask all", would report the wrong top word. Claims are checked against the level mode and input of the winner, since a design that always re-pends or never re-pends would leave level sources stuck or lost. The sweeps also cover empty claims with force set, targets aimed at absent harts, priority-zero target writes, and source 0 held pending, each of which a careless decode would turn into a spurious interrupt.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam int TGT_HART_LSB = 18;
    localparam int TGT_HART_W   = 14;
    localparam int TOPI_ID_LSB  = 16;

    localparam logic [4:0] OFF_DELIV  = 5'h00;
    localparam logic [4:0] OFF_FORCE  = 5'h04;
    localparam logic [4:0] OFF_THRESH = 5'h08;
    localparam logic [4:0] OFF_TOPI   = 5'h18;
    localparam logic [4:0] OFF_CLAIM  = 5'h1C;

    function automatic logic [TGT_HART_W-1:0] tgt_hart(input logic [31:0] w);
        return w[TGT_HART_LSB +: TGT_HART_W];
    endfunction

endpackage

// File: rtl/hpc_tgt_store.sv
module hpc_tgt_store #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int SRC_W   = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [SRC_W-1:0]          sel,
    input  logic [31:0]               wdata,
    output logic [NUM_SRC-1:0][31:0]  tgt
);
    localparam logic [31:0] RST_WORD = 32'd1;

    typedef struct packed {
        logic [NUM_SRC-1:0][31:0] word;
    } st_t;

    st_t st_d, st_q;
    logic [31:0] norm_w;

    always_comb begin
        norm_w = wdata;
        if (wdata[PRIO_W-1:0] == '0) begin
            norm_w[PRIO_W-1:0] = PRIO_W'(1);
        end
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (we && sel == SRC_W'(i)) begin
                st_d.word[i] = norm_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                st_q.word[i] <= RST_WORD;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign tgt = st_q.word;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chk
        // R8: a zero priority written lands as priority 1
        p_zero_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == SRC_W'(gi) && wdata[PRIO_W-1:0] == '0)
            |=> (tgt[gi][PRIO_W-1:0] == PRIO_W'(1)));
    end

endmodule

// File: rtl/hpc_hart_regs.sv
module hpc_hart_regs
    import hpc_pkg::*;
#(
    parameter int NUM_HART = 4,
    parameter int PRIO_W   = 3,
    parameter int HART_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [HART_W-1:0]                 hsel,
    input  logic [4:0]                        off,
    input  logic [31:0]                       wdata,
    input  logic [NUM_HART-1:0]               frc_clr,
    output logic [NUM_HART-1:0]               deliv,
    output logic [NUM_HART-1:0]               frc,
    output logic [NUM_HART-1:0][PRIO_W-1:0]   thr
);
    typedef struct packed {
        logic [NUM_HART-1:0]             deliv;
        logic [NUM_HART-1:0]             frc;
        logic [NUM_HART-1:0][PRIO_W-1:0] thr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int h = 0; h < NUM_HART; h++) begin
            if (frc_clr[h]) begin
                st_d.frc[h] = 1'b0;
            end
            if (we && hsel == HART_W'(h)) begin
                unique case (off)
                    OFF_DELIV:  st_d.deliv[h] = wdata[0];
                    OFF_FORCE:  st_d.frc[h]   = wdata[0];
                    OFF_THRESH: st_d.thr[h]   = wdata[PRIO_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign deliv = st_q.deliv;
    assign frc   = st_q.frc;
    assign thr   = st_q.thr;

    for (genvar gh = 0; gh < NUM_HART; gh++) begin : g_chk
        // R7: an empty claim drops the force bit on the next cycle
        p_force_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (frc_clr[gh] && !we) |=> !frc[gh]);
    end

    // R9: without a write strobe the threshold and delivery bits hold
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(thr) && $stable(deliv)));

endmodule

// File: rtl/hpc_sel.sv
module hpc_sel
    import hpc_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int PRIO_W   = 3,
    parameter int SRC_W    = 5,
    parameter int HART_IDX = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        cand,
    input  logic [NUM_SRC-1:0][31:0]  tgt,
    input  logic [PRIO_W-1:0]         thresh,
    output logic [31:0]               topi
);
    localparam logic [TGT_HART_W-1:0] MY_HART = TGT_HART_W'(HART_IDX);

    logic              found;
    logic [PRIO_W-1:0] best_p;
    logic [SRC_W-1:0]  best_i;
    logic [PRIO_W-1:0] cur_p;
    logic              hit;

    always_comb begin
        found  = 1'b0;
        best_p = '1;
        best_i = '0;
        cur_p  = '0;
        hit    = 1'b0;
        for (int i = 1; i < NUM_SRC; i++) begin
            cur_p = tgt[i][PRIO_W-1:0];
            hit   = cand[i] && (tgt_hart(tgt[i]) == MY_HART) &&
                    ((thresh == '0) || (cur_p < thresh));
            if (hit && (!found || cur_p < best_p)) begin
                found  = 1'b1;
                best_p = cur_p;
                best_i = SRC_W'(i);
            end
        end
        topi = '0;
        if (found) begin
            topi[TOPI_ID_LSB +: SRC_W] = best_i;
            topi[PRIO_W-1:0]           = best_p;
        end
    end

    // R3: a reported winner sits strictly below a nonzero threshold
    p_under_thr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (topi != '0 && thresh != '0) |-> (topi[PRIO_W-1:0] < thresh));

    // R10: a reported winner is enabled and pending
    p_is_cand_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (topi != '0) |-> cand[topi[TOPI_ID_LSB +: SRC_W]]);

    // R1: a reported winner targets this hart
    p_hart_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (topi != '0) |-> (tgt_hart(tgt[topi[TOPI_ID_LSB +: SRC_W]]) == MY_HART));

    // R2: source 0 is never reported
    p_no_src0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (topi != '0) |-> (topi[TOPI_ID_LSB +: SRC_W] != '0));

endmodule

// File: rtl/hart_prio_claim.sv
module hart_prio_claim
    import hpc_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_HART = 4,
    parameter int PRIO_W   = 3,
    localparam int SRC_W   = (NUM_SRC  > 1) ? $clog2(NUM_SRC)  : 1,
    localparam int HART_W  = (NUM_HART > 1) ? $clog2(NUM_HART) : 1,
    localparam int ADDR_W  = HART_W + 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dom_ie,
    input  logic [NUM_SRC-1:0]   src_en,
    input  logic [NUM_SRC-1:0]   src_pend,
    input  logic [NUM_SRC-1:0]   src_in,
    input  logic [NUM_SRC-1:0]   src_lvl_hi,
    input  logic [NUM_SRC-1:0]   src_lvl_lo,
    input  logic                 tgt_we,
    input  logic [SRC_W-1:0]     tgt_sel,
    input  logic [31:0]          tgt_wdata,
    input  logic                 reg_we,
    input  logic                 reg_re,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_SRC-1:0]   pend_clr,
    output logic [NUM_SRC-1:0]   pend_set,
    output logic [NUM_HART-1:0]  irq_out
);
    logic [NUM_SRC-1:0][31:0]        tgt;
    logic [NUM_SRC-1:0]              cand;
    logic [NUM_HART-1:0][31:0]       topi;
    logic [NUM_HART-1:0]             deliv;
    logic [NUM_HART-1:0]             frc;
    logic [NUM_HART-1:0][PRIO_W-1:0] thr;
    logic [NUM_HART-1:0]             frc_clr;
    logic [HART_W-1:0]               hsel;
    logic [4:0]                      off;
    logic                            hsel_ok;
    logic [31:0]                     sel_topi;
    logic [SRC_W-1:0]                cid;
    logic                            claim_hit;

    assign hsel    = reg_addr[ADDR_W-1:5];
    assign off     = reg_addr[4:0];
    assign hsel_ok = (32'(hsel) < NUM_HART);
    assign cand    = src_en & src_pend;

    hpc_tgt_store #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .SRC_W   (SRC_W)
    ) u_tgt (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tgt_we),
        .sel   (tgt_sel),
        .wdata (tgt_wdata),
        .tgt   (tgt)
    );

    hpc_hart_regs #(
        .NUM_HART (NUM_HART),
        .PRIO_W   (PRIO_W),
        .HART_W   (HART_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we && hsel_ok),
        .hsel    (hsel),
        .off     (off),
        .wdata   (reg_wdata),
        .frc_clr (frc_clr),
        .deliv   (deliv),
        .frc     (frc),
        .thr     (thr)
    );

    for (genvar gh = 0; gh < NUM_HART; gh++) begin : g_hart
        hpc_sel #(
            .NUM_SRC  (NUM_SRC),
            .PRIO_W   (PRIO_W),
            .SRC_W    (SRC_W),
            .HART_IDX (gh)
        ) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .cand   (cand),
            .tgt    (tgt),
            .thresh (thr[gh]),
            .topi   (topi[gh])
        );

        assign irq_out[gh] = dom_ie && deliv[gh] && (frc[gh] || (topi[gh] != '0));
    end

    always_comb begin
        sel_topi = '0;
        for (int h = 0; h < NUM_HART; h++) begin
            if (hsel == HART_W'(h)) begin
                sel_topi = topi[h];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hsel_ok) begin
            for (int h = 0; h < NUM_HART; h++) begin
                if (hsel == HART_W'(h)) begin
                    unique case (off)
                        OFF_DELIV:  reg_rdata = {31'd0, deliv[h]};
                        OFF_FORCE:  reg_rdata = {31'd0, frc[h]};
                        OFF_THRESH: reg_rdata = 32'(thr[h]);
                        OFF_TOPI,
                        OFF_CLAIM:  reg_rdata = topi[h];
                        default:    reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    assign claim_hit = reg_re && hsel_ok && (off == OFF_CLAIM);
    assign cid       = sel_topi[TOPI_ID_LSB +: SRC_W];

    always_comb begin
        pend_clr = '0;
        pend_set = '0;
        frc_clr  = '0;
        if (claim_hit) begin
            if (sel_topi == '0) begin
                for (int h = 0; h < NUM_HART; h++) begin
                    if (hsel == HART_W'(h)) begin
                        frc_clr[h] = 1'b1;
                    end
                end
            end else begin
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (cid == SRC_W'(i)) begin
                        pend_clr[i] = 1'b1;
                        pend_set[i] = (src_lvl_hi[i] && src_in[i]) ||
                                      (src_lvl_lo[i] && !src_in[i]);
                    end
                end
            end
        end
    end

    // R6: a claim clears at most one source
    p_clr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr));

    // R6: a re-pend pulse only accompanies a clear of the same source
    p_set_in_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_set & ~pend_clr) == '0));

    // R6: outside a read nothing is cleared
    p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |-> (pend_clr == '0 && pend_set == '0));

    // R5: no line rises while the domain is disabled
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_ie |-> (irq_out == '0));

endmodule

// File: tb/hart_prio_claim_bench.sv
module hart_prio_claim_bench;
    localparam int NS = 8;
    localparam int NH = 2;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dom_ie = 1'b0;
    logic [NS-1:0] src_en = '0, src_pend = '0, src_in = '0, lvl_hi = '0, lvl_lo = '0;
    logic tgt_we = 1'b0;
    logic [2:0] tgt_sel = '0;
    logic [31:0] tgt_wdata = '0;
    logic reg_we = 1'b0, reg_re = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NS-1:0] pend_clr, pend_set;
    logic [NH-1:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    int m_hart [NS];
    int m_prio [NS];
    int m_thr  [NH];
    logic [NH-1:0] m_dlv = '0, m_frc = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    hart_prio_claim #(.NUM_SRC(NS), .NUM_HART(NH), .PRIO_W(PW)) u_hart_prio_claim (
        .clk(clk), .rst_n(rst_n), .dom_ie(dom_ie),
        .src_en(src_en), .src_pend(src_pend), .src_in(src_in),
        .src_lvl_hi(lvl_hi), .src_lvl_lo(lvl_lo),
        .tgt_we(tgt_we), .tgt_sel(tgt_sel), .tgt_wdata(tgt_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pend_clr(pend_clr), .pend_set(pend_set), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] exp_topi(input int h);
        int bp = 99;
        int bi = 0;
        for (int i = 1; i < NS; i++) begin
            if (src_en[i] && src_pend[i] && m_hart[i] == h &&
                (m_thr[h] == 0 || m_prio[i] < m_thr[h]) && m_prio[i] < bp) begin
                bp = m_prio[i];
                bi = i;
            end
        end
        return (bi == 0) ? 32'd0 : ((32'(bi) << 16) | 32'(bp));
    endfunction

    function automatic logic [NH-1:0] exp_irq();
        logic [NH-1:0] r;
        for (int h = 0; h < NH; h++)
            r[h] = dom_ie && m_dlv[h] && (m_frc[h] || exp_topi(h) != 0);
        return r;
    endfunction

    task automatic wr_tgt(input int s, input int h, input int p, input logic [31:0] junk);
        @(negedge clk);
        tgt_we = 1'b1;
        tgt_sel = 3'(s);
        tgt_wdata = (32'(h) << 18) | (junk & 32'h0003_FFF8) | 32'(p & 7);
        @(negedge clk);
        tgt_we = 1'b0;
        m_hart[s] = h;
        m_prio[s] = ((p & 7) == 0) ? 1 : (p & 7);
    endtask

    task automatic wr_reg(input int h, input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = {1'(h), off};
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (off == 5'h00) m_dlv[h] = d[0];
        if (off == 5'h04) m_frc[h] = d[0];
        if (off == 5'h08) m_thr[h] = int'(d[2:0]);
    endtask

    task automatic rd_reg(input int h, input logic [4:0] off, output logic [31:0] d,
                          output logic [NS-1:0] c, output logic [NS-1:0] s);
        @(negedge clk);
        reg_re = 1'b1;
        reg_addr = {1'(h), off};
        #1;
        d = reg_rdata;
        c = pend_clr;
        s = pend_set;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic set_src(input logic [NS-1:0] en, input logic [NS-1:0] pd);
        @(negedge clk);
        src_en = en;
        src_pend = pd;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [NS-1:0] c, s, ec, es;
        int h;
        for (int i = 0; i < NS; i++) begin m_hart[i] = 0; m_prio[i] = 1; end
        for (int i = 0; i < NH; i++) m_thr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R4, R5, R9)
        rd_reg(0, 5'h18, d, c, s); chk("R4 reset topi", d, 0);
        rd_reg(1, 5'h00, d, c, s); chk("R9 reset deliv", d, 0);
        rd_reg(1, 5'h08, d, c, s); chk("R9 reset thresh", d, 0);
        #1 chk("R5 reset irq", 32'(irq_out), 0);

        // R8: reset targets point to hart 0 at priority 1
        set_src(8'b0000_1000, 8'b0000_1000);
        rd_reg(0, 5'h18, d, c, s); chk("R8 reset target", d, 32'h0003_0001);
        rd_reg(1, 5'h18, d, c, s); chk("R1 other hart empty", d, 0);

        // R2: tie on priority goes to lowest source; source 0 ignored
        set_src(8'b0010_1101, 8'b0010_1101);
        rd_reg(0, 5'h18, d, c, s); chk("R2 tie lowest source", d, 32'h0002_0001);
        // R10: enabled but not pending does not compete
        set_src(8'b0010_1101, 8'b0010_1001);
        rd_reg(0, 5'h18, d, c, s); chk("R10 pending required", d, 32'h0003_0001);

        // R8: zero priority written stored as 1
        wr_tgt(2, 0, 4, 0); wr_tgt(3, 0, 5, 0); wr_tgt(5, 0, 0, 32'hFFFF_FFFF);
        set_src(8'b0010_1100, 8'b0010_1100);
        rd_reg(0, 5'h18, d, c, s); chk("R8 zero prio to 1", d, 32'h0005_0001);
        // R1: hart field beyond the harts reaches nobody
        wr_tgt(5, 3, 1, 0);
        rd_reg(0, 5'h18, d, c, s); chk("R1 absent hart", d, 32'h0002_0004);
        rd_reg(1, 5'h18, d, c, s); chk("R1 absent hart h1", d, 0);

        // R9: masking, unmapped offsets, read-only top word
        wr_reg(1, 5'h00, 32'hFFFF_FFFF); rd_reg(1, 5'h00, d, c, s); chk("R9 deliv bit0", d, 1);
        wr_reg(1, 5'h04, 32'h0000_0002); rd_reg(1, 5'h04, d, c, s); chk("R9 force bit0", d, 0);
        wr_reg(1, 5'h08, 32'h0000_00FF); rd_reg(1, 5'h08, d, c, s); chk("R9 thresh mask", d, 7);
        wr_reg(1, 5'h0C, 32'hFFFF_FFFF); rd_reg(1, 5'h0C, d, c, s); chk("R9 unmapped", d, 0);
        rd_reg(1, 5'h08, d, c, s); chk("R9 unmapped write no effect", d, 7);
        wr_reg(0, 5'h18, 32'h0007_0007); rd_reg(0, 5'h18, d, c, s); chk("R4 topi read-only", d, 32'h0002_0004);
        wr_reg(1, 5'h08, 0); wr_reg(1, 5'h00, 0);

        // R3: threshold edge on hart 0 (priorities 4 and 5 present)
        wr_reg(0, 5'h08, 4); rd_reg(0, 5'h18, d, c, s); chk("R3 thr equal excluded", d, 0);
        wr_reg(0, 5'h08, 5); rd_reg(0, 5'h18, d, c, s); chk("R3 thr above kept", d, 32'h0002_0004);
        wr_reg(0, 5'h08, 0); rd_reg(0, 5'h18, d, c, s); chk("R3 thr zero", d, 32'h0002_0004);

        // R5: irq gating
        wr_reg(0, 5'h00, 1);
        #1 chk("R5 irq needs dom_ie", 32'(irq_out), 0);
        @(negedge clk); dom_ie = 1'b1; #1;
        chk("R5 irq on", 32'(irq_out), 1);
        set_src(8'b0, 8'b0);
        chk("R5 irq off no candidate", 32'(irq_out), 0);
        wr_reg(0, 5'h04, 1);
        #1 chk("R5 irq by force", 32'(irq_out), 1);

        // R7: empty claim returns 0, pulses nothing, clears force
        rd_reg(0, 5'h1C, d, c, s);
        chk("R7 empty claim value", d, 0);
        chk("R7 empty claim no pulse", 32'({c, s}), 0);
        rd_reg(0, 5'h04, d, c, s); chk("R7 force cleared", d, 0);
        #1 chk("R7 irq drops", 32'(irq_out), 0);

        // R6: claims with level modes
        wr_tgt(4, 1, 2, 0); wr_tgt(6, 1, 3, 0); wr_tgt(1, 1, 4, 0); wr_tgt(7, 1, 5, 0);
        @(negedge clk);
        lvl_hi = 8'b1001_0000; lvl_lo = 8'b0100_0000; src_in = 8'b0001_0000;
        set_src(8'b1101_0010, 8'b1101_0010);
        rd_reg(1, 5'h1C, d, c, s);
        chk("R6 claim value hi", d, 32'h0004_0002);
        chk("R6 clr hi", 32'(c), 32'h10); chk("R6 repend hi", 32'(s), 32'h10);
        set_src(8'b1101_0010, 8'b1100_0010);
        rd_reg(1, 5'h1C, d, c, s);
        chk("R6 claim value lo", d, 32'h0006_0003);
        chk("R6 clr lo", 32'(c), 32'h40); chk("R6 repend lo", 32'(s), 32'h40);
        @(negedge clk); src_in = 8'b0100_0000;
        set_src(8'b1101_0010, 8'b1000_0010);
        rd_reg(1, 5'h1C, d, c, s);
        chk("R6 claim edge", d, 32'h0001_0004);
        chk("R6 clr edge", 32'(c), 32'h02); chk("R6 no repend edge", 32'(s), 0);
        set_src(8'b1101_0010, 8'b1000_0000);
        rd_reg(1, 5'h1C, d, c, s);
        chk("R6 claim hi inactive", d, 32'h0007_0005);
        chk("R6 no repend inactive", 32'(s), 0);

        // Sweep: random targets, vectors, thresholds, controls (R1-R6, R10)
        for (int it = 0; it < 40; it++) begin
            for (int sidx = 1; sidx < NS; sidx++) begin
                logic [31:0] r = rnd();
                wr_tgt(sidx, int'(r[1:0]) % 3, int'(r[4:2]), r);
            end
            d = rnd();
            wr_reg(0, 5'h08, (d[2:0] > 4) ? 0 : 32'(d[2:0]));
            wr_reg(1, 5'h08, (d[5:3] > 4) ? 0 : 32'(d[5:3]));
            wr_reg(0, 5'h00, 32'(d[6])); wr_reg(1, 5'h00, 32'(d[7]));
            wr_reg(0, 5'h04, 32'(d[8] & d[9])); wr_reg(1, 5'h04, 32'(d[10] & d[11]));
            @(negedge clk);
            dom_ie = d[12] | d[13];
            lvl_hi = d[23:16]; lvl_lo = d[31:24] & ~d[23:16]; src_in = rnd();
            d = rnd();
            set_src(d[7:0] | d[15:8], d[23:16] | d[31:24]);
            for (int hh = 0; hh < NH; hh++) begin
                rd_reg(hh, 5'h18, d, c, s);
                chk("R4 sweep topi", d, exp_topi(hh));
            end
            #1 chk("R5 sweep irq", 32'(irq_out), 32'(exp_irq()));
            h = it % NH;
            d = exp_topi(h);
            ec = '0; es = '0;
            if (d != 0) begin
                ec[d[18:16]] = 1'b1;
                es[d[18:16]] = (lvl_hi[d[18:16]] && src_in[d[18:16]]) ||
                               (lvl_lo[d[18:16]] && !src_in[d[18:16]]);
            end
            begin
                logic [31:0] got;
                rd_reg(h, 5'h1C, got, c, s);
                chk("R6 sweep claim value", got, d);
                chk("R6 sweep clr", 32'(c), 32'(ec));
                chk("R6 sweep set", 32'(s), 32'(es));
                if (d == 0) m_frc[h] = 1'b0;
            end
            set_src(src_en, (src_pend & ~ec) | es);
            chk("R7 sweep irq after claim", 32'(irq_out), 32'(exp_irq()));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule